// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM of 131,072 words of 16 bits. The host presents one request at a time through a valid/ready handshake: a 17-bit word address, a read or write flag, 16 bits of write data and a two-bit lane mask. The controller turns each request into a timed sequence of active-low strobes (chip select, output enable, write enable and one enable per byte lane). Each read returns its data with a one-cycle response pulse. Each write also ends with a response pulse, and its returned data is zero.

Every phase length is a whole number of clock cycles. It is worked out when the block is elaborated, by rounding up the memory's nanosecond limits at the chosen clock period. The memory data bus is split into an output word, an input word and a drive enable, so that the pad buffer can live outside the block. After the memory's output enable is released, the controller keeps its own drivers off the bus until the memory's output stage has had time to go high-impedance.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1.
- R2: Bit 0 of req_mask selects the lower lane (data bits 7:0), and that lane is strobed by driving mem_lb_n to 0. Bit 1 selects the upper lane (bits 15:8), strobed by driving mem_ub_n to 0. A deselected lane's strobe stays at 1 for the whole access.
- R3: A read accepted at a clock edge holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, starting in the next cycle, with mem_addr equal to the requested address.
- R4: Read data is sampled at the edge that ends the last output-enable cycle. It is returned in the following cycle together with a one-cycle rsp_valid, and the strobes are already released in that cycle. Lanes not selected in the mask read back as zero.
- R5: A write runs in three phases. First, one setup cycle with chip select and lane strobes low, mem_we_n=1 and the bus driven. Next, WP_CYC cycles with mem_we_n=0. Last, REC_CYC recovery cycles with mem_we_n=1, chip select low and the bus still driven. rsp_valid with rdata 0 follows in the next cycle, which is idle.
- R6: mem_addr and mem_dq_out hold the same value across the cycles in which mem_we_n falls and rises.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0. It only goes to 1 after mem_oe_n has been 1 for at least TURN_CYC consecutive cycles. When that has not yet happened, all strobes stay inactive and the controller waits.
- R8: A request with req_mask equal to 0 touches no strobe. rsp_valid is 1 with rdata 0 in the next cycle, and req_ready stays at 1.
- R9: req_ready drops in the cycle after a request with a non-empty mask is accepted, and stays 0 until the access completes. Requests presented while req_ready is 0 are ignored: they change neither the strobes nor the memory.
- R10: mem_cs_n is never 0 with both lane strobes at 1. Between accesses, every strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower, bit 1 upper |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The turnaround wait is the hardest situation to reach, because it only appears when a write is accepted within a few cycles of a read releasing output enable. The stimulus therefore issues a write in the very first idle cycle after a read response, and the reference model has to predict exactly how many wait cycles come before the setup cycle. The same model also covers writes after a long idle period, which must start at once. A second stimulus pattern keeps a conflicting write request asserted while a read is in flight. The address that request names is then read back to show that it was never written.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RD_ACCESS  = 3'd1,
      ST_RD_CAPTURE = 3'd2,
      ST_TURNAROUND = 3'd3,
      ST_WR_SETUP   = 3'd4,
      ST_WR_PULSE   = 3'd5,
      ST_WR_RECOVER = 3'd6
   } ctl_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_quiet.sv
module sram_lane_quiet #(
   parameter int TURN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic drive_ok
);
   localparam int QW = $clog2(TURN_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(TURN_CYC);

   logic [QW-1:0] quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quiet <= QMAX;
      else if (!oe_n)
         quiet <= '0;
      else if (quiet < QMAX)
         quiet <= quiet + 1'b1;
   end

   // true when the next cycle will follow TURN_CYC released cycles
   assign drive_ok = (int'(quiet) + 1) >= TURN_CYC;
endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic                    clr,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dout[g*LANE_W +: LANE_W] <= '0;
         else if (clr)
            dout[g*LANE_W +: LANE_W] <= '0;
         else if (cap)
            dout[g*LANE_W +: LANE_W] <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
      end
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int LANE_W   = 8,
   parameter int LANES    = 2,
   parameter int CLK_PS   = 8000,
   parameter int T_RC_PS  = 55000,
   parameter int T_WP_PS  = 45000,
   parameter int T_SD_PS  = 25000,
   parameter int T_HZ_PS  = 30000,
   parameter int RD_CYC   = ceil_div(T_RC_PS, CLK_PS),
   parameter int WP_CYC   = ceil_div(T_WP_PS, CLK_PS),
   parameter int SD_CYC   = ceil_div(T_SD_PS, CLK_PS),
   parameter int TURN_CYC = ceil_div(T_HZ_PS, CLK_PS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LANES*LANE_W-1:0] req_wdata,
   input  logic [LANES-1:0]        req_mask,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic [LANES*LANE_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    mem_cs_n,
   output logic                    mem_oe_n,
   output logic                    mem_we_n,
   output logic                    mem_ub_n,
   output logic                    mem_lb_n,
   output logic [LANES*LANE_W-1:0] mem_dq_out,
   input  logic [LANES*LANE_W-1:0] mem_dq_in,
   output logic                    mem_dq_oe
);
   localparam int DATA_W  = LANES * LANE_W;
   localparam int REC_RAW = RD_CYC - 1 - WP_CYC;
   localparam int REC_CYC = (REC_RAW < 1) ? 1 : REC_RAW;
   localparam int MAX_CYC = max_of(max_of(RD_CYC, WP_CYC), REC_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (LANES != 2)
      $error("two byte lanes are required");
   if (RD_CYC < 2 || WP_CYC < 1 || TURN_CYC < 1)
      $error("phase lengths too short");
   if (SD_CYC > WP_CYC + 1)
      $error("data setup does not fit in setup plus pulse");
   if (DATA_W != 16 || ADDR_W < 1)
      $error("unsupported bus shape");

   ctl_state_t state, nxt;
   logic             tmr_done, tmr_load, drive_ok, accept;
   logic [CNT_W-1:0] tmr_val;
   logic [LANES-1:0] mask_q, mask_n, lane_n;
   logic             sel_n, cap, clr;

   assign accept = (state == ST_IDLE) && req_valid;
   assign mask_n = accept ? req_mask : mask_q;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req_valid && req_mask != '0)
                     nxt = !req_write ? ST_RD_ACCESS :
                           (drive_ok ? ST_WR_SETUP : ST_TURNAROUND);
         ST_RD_ACCESS:  if (tmr_done) nxt = ST_RD_CAPTURE;
         ST_RD_CAPTURE: nxt = ST_IDLE;
         ST_TURNAROUND: if (drive_ok) nxt = ST_WR_SETUP;
         ST_WR_SETUP:   nxt = ST_WR_PULSE;
         ST_WR_PULSE:   if (tmr_done) nxt = ST_WR_RECOVER;
         ST_WR_RECOVER: if (tmr_done) nxt = ST_IDLE;
         default:       nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (nxt)
         ST_RD_ACCESS:  tmr_val = CNT_W'(RD_CYC - 1);
         ST_WR_PULSE:   tmr_val = CNT_W'(WP_CYC - 1);
         ST_WR_RECOVER: tmr_val = CNT_W'(REC_CYC - 1);
         default:       tmr_val = '0;
      endcase
   end
   assign tmr_load = (nxt != state);

   assign sel_n = !(nxt == ST_RD_ACCESS || nxt == ST_WR_SETUP ||
                    nxt == ST_WR_PULSE  || nxt == ST_WR_RECOVER);
   assign cap   = (state == ST_RD_ACCESS) && tmr_done;
   assign clr   = ((state == ST_WR_RECOVER) && tmr_done) ||
                  (accept && req_mask == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         req_ready  <= 1'b1;
         rsp_valid  <= 1'b0;
         mem_cs_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mask_q     <= '0;
      end else begin
         state      <= nxt;
         req_ready  <= (nxt == ST_IDLE);
         rsp_valid  <= cap || clr;
         mem_cs_n   <= sel_n;
         mem_oe_n   <= !(nxt == ST_RD_ACCESS);
         mem_we_n   <= !(nxt == ST_WR_PULSE);
         mem_dq_oe  <= (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE) ||
                       (nxt == ST_WR_RECOVER);
         mask_q     <= mask_n;
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_strobe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_n[g] <= 1'b1;
         else
            lane_n[g] <= sel_n || !mask_n[g];
      end
   end
   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

   sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
   );

   sram_lane_quiet #(.TURN_CYC(TURN_CYC)) u_quiet (
      .clk(clk), .rst_n(rst_n), .oe_n(mem_oe_n), .drive_ok(drive_ok)
   );

   sram_lane_rdcap #(.LANE_W(LANE_W), .LANES(LANES)) u_rdcap (
      .clk(clk), .rst_n(rst_n), .cap(cap), .clr(clr), .lane_en(mask_q),
      .din(mem_dq_in), .dout(rsp_rdata)
   );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter int WP_CYC   = 6,
   parameter int TURN_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [LANES-1:0]  req_mask,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_ub_n,
   input logic              mem_lb_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out
);
   int quiet_run;
   int we_low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_run  <= TURN_CYC;
         we_low_run <= 0;
      end else begin
         if (!mem_oe_n)
            quiet_run <= 0;
         else if (quiet_run < TURN_CYC)
            quiet_run <= quiet_run + 1;
         we_low_run <= mem_we_n ? 0 : we_low_run + 1;
      end
   end

   AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_cs_n));  // R3
   AST_RSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_cs_n && mem_oe_n));  // R4
   AST_WE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));  // R5
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_run == WP_CYC));  // R5
   AST_WE_FALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));  // R6
   AST_WE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out)));  // R6
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);  // R7
   AST_TURN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (quiet_run >= TURN_CYC));  // R7
   AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask == '0) |=> (rsp_valid && req_ready && mem_cs_n));  // R8
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask != '0) |=> !req_ready);  // R9
   AST_SELECT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !(mem_ub_n && mem_lb_n));  // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W), .LANES(LANES),
   .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
   .req_ready(req_ready), .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n),
   .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
   .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
   .mem_dq_out(mem_dq_out)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
   localparam int CLKP = 8000;
   localparam int RD   = (55000 + CLKP - 1) / CLKP;
   localparam int WP   = (45000 + CLKP - 1) / CLKP;
   localparam int TURN = (30000 + CLKP - 1) / CLKP;
   localparam int REC  = (RD - 1 - WP < 1) ? 1 : RD - 1 - WP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in = '0;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   sram_lane_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory attached to the pins -------------
   logic [15:0] sram [logic [16:0]];
   function automatic logic [15:0] sram_rd(input logic [16:0] a);
      return sram.exists(a) ? sram[a] : 16'h0000;
   endfunction

   always @(negedge clk) begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         logic [15:0] w;
         w = sram_rd(mem_addr);
         mem_dq_in <= {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hC3 : w[7:0]};
      end else
         mem_dq_in <= 16'h5A5A;
   end

   always @(posedge mem_we_n) begin
      if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) begin
         logic [15:0] w;
         w = sram_rd(mem_addr);
         if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
         if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
         sram[mem_addr] = w;
      end
   end

   // ---------------- cycle-by-cycle reference model ----------------------
   typedef struct packed {
      logic rdy, rv, cs, oe, we, ub, lb, doe;
      logic [16:0] a;
      logic [15:0] d;
      logic [15:0] rd;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   run;
   logic [15:0] ref_mem [logic [16:0]];

   function automatic logic [15:0] ref_rd(input logic [16:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
   endfunction

   function automatic exp_t idle_rec();
      exp_t e;
      e = '0;
      e.rdy = 1'b1; e.cs = 1'b1; e.oe = 1'b1; e.we = 1'b1; e.ub = 1'b1; e.lb = 1'b1;
      return e;
   endfunction

   initial cur = idle_rec();

   always @(posedge clk) begin
      exp_t e;
      int r;
      if (!rst_n) begin
         q.delete();
         cur = idle_rec();
         run = TURN;
      end else begin
         r = run;
         if (cur.oe) run = (run < TURN) ? run + 1 : run;
         else run = 0;
         if (cur.rdy && req_valid) begin
            if (req_mask == 2'b00) begin
               e = idle_rec(); e.rv = 1'b1; q.push_back(e);
            end else if (!req_write) begin
               e = idle_rec(); e.rdy = 1'b0; e.cs = 1'b0; e.oe = 1'b0;
               e.ub = !req_mask[1]; e.lb = !req_mask[0]; e.a = req_addr;
               for (int k = 0; k < RD; k++) q.push_back(e);
               e = idle_rec(); e.rdy = 1'b0; e.rv = 1'b1;
               e.rd = ref_rd(req_addr) & {{8{req_mask[1]}}, {8{req_mask[0]}}};
               q.push_back(e);
            end else begin
               int w;
               w = TURN - r - 1;
               e = idle_rec(); e.rdy = 1'b0;
               for (int k = 0; k < w; k++) q.push_back(e);
               e.cs = 1'b0; e.doe = 1'b1; e.ub = !req_mask[1]; e.lb = !req_mask[0];
               e.a = req_addr; e.d = req_wdata;
               q.push_back(e);
               e.we = 1'b0;
               for (int k = 0; k < WP; k++) q.push_back(e);
               e.we = 1'b1;
               for (int k = 0; k < REC; k++) q.push_back(e);
               e = idle_rec(); e.rv = 1'b1; q.push_back(e);
               begin
                  logic [15:0] m;
                  m = ref_rd(req_addr);
                  if (req_mask[0]) m[7:0]  = req_wdata[7:0];
                  if (req_mask[1]) m[15:8] = req_wdata[15:8];
                  ref_mem[req_addr] = m;
               end
            end
         end
         cur = (q.size() > 0) ? q.pop_front() : idle_rec();
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R9 req_ready", {31'd0, req_ready}, {31'd0, cur.rdy});
         check("R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, cur.rv});
         check("R10 mem_cs_n", {31'd0, mem_cs_n}, {31'd0, cur.cs});
         check("R3 mem_oe_n", {31'd0, mem_oe_n}, {31'd0, cur.oe});
         check("R5 mem_we_n", {31'd0, mem_we_n}, {31'd0, cur.we});
         check("R2 lanes", {30'd0, mem_ub_n, mem_lb_n}, {30'd0, cur.ub, cur.lb});
         check("R7 mem_dq_oe", {31'd0, mem_dq_oe}, {31'd0, cur.doe});
         if (!cur.cs) check("R3 mem_addr", {15'd0, mem_addr}, {15'd0, cur.a});
         if (cur.doe) check("R6 mem_dq_out", {16'd0, mem_dq_out}, {16'd0, cur.d});
         if (cur.rv) check("R4 rsp_rdata", {16'd0, rsp_rdata}, {16'd0, cur.rd});
      end
   end

   // ---------------- stimulus --------------------------------------------
   task automatic do_req(input logic wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, output logic [15:0] rd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
   endtask

   task automatic rd_check(input string tag, input logic [16:0] a, input logic [1:0] m);
      logic [15:0] got, exp;
      exp = ref_rd(a) & {{8{m[1]}}, {8{m[0]}}};
      do_req(1'b0, a, 16'h0, m, got);
      check(tag, {16'd0, got}, {16'd0, exp});
   endtask

   initial begin
      logic [15:0] dummy;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
      check("R1 strobes in reset",
            {26'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            {26'd0, 6'b111110});
      check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

      // R5 full write after long idle, then R4 reads with each mask (R2)
      do_req(1'b1, 17'h00010, 16'hBEEF, 2'b11, dummy);
      check("R5 write rdata zero", {16'd0, dummy}, 32'd0);
      rd_check("R4 full read", 17'h00010, 2'b11);
      rd_check("R2 lower only read", 17'h00010, 2'b01);
      rd_check("R2 upper only read", 17'h00010, 2'b10);

      // R2 lower-only write, upper must survive
      do_req(1'b1, 17'h00010, 16'h1234, 2'b01, dummy);
      rd_check("R2 lower write merged", 17'h00010, 2'b11);
      do_req(1'b1, 17'h00010, 16'h9900, 2'b10, dummy);
      rd_check("R2 upper write merged", 17'h00010, 2'b11);

      // R7 write right after a read: turnaround wait cycles
      rd_check("R7 read before write", 17'h00010, 2'b11);
      do_req(1'b1, 17'h00020, 16'hCAFE, 2'b11, dummy);
      rd_check("R7 data after turnaround write", 17'h00020, 2'b11);

      // R8 empty masks
      do_req(1'b0, 17'h00010, 16'h0, 2'b00, dummy);
      check("R8 empty read data", {16'd0, dummy}, 32'd0);
      check("R8 ready kept", {31'd0, req_ready}, 32'd1);
      do_req(1'b1, 17'h00010, 16'hFFFF, 2'b00, dummy);
      rd_check("R8 empty write left memory", 17'h00010, 2'b11);

      // R9 conflicting request held while busy is ignored
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00010; req_mask = 2'b11;
      @(negedge clk);
      req_write = 1'b1; req_addr = 17'h00033; req_wdata = 16'hDEAD; req_mask = 2'b11;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      rd_check("R9 busy write ignored", 17'h00033, 2'b11);

      // R3 address boundaries
      do_req(1'b1, 17'h1FFFF, 16'hA1B2, 2'b11, dummy);
      do_req(1'b1, 17'h00000, 16'h0F0F, 2'b11, dummy);
      rd_check("R3 top address", 17'h1FFFF, 2'b11);
      rd_check("R3 bottom address", 17'h00000, 2'b11);

      // pattern sweep, R10 strobes checked each cycle by the model
      for (int i = 0; i < 16; i++)
         do_req(1'b1, 17'((i * 17'h1111) & 17'h1FFFF), 16'(i * 16'h0F1D + 16'h0101),
                2'((i % 3) + 1), dummy);
      for (int i = 15; i >= 0; i--)
         rd_check("R10 sweep read", 17'((i * 17'h1111) & 17'h1FFFF), 2'((i % 3) + 1));

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule